// File: doc/BRIEF.md
# Processor Interrupt Presentation Unit with Inter-Processor Interrupt

This unit sits between the interrupt sources of a system and one processor. It holds one pending interrupt, which is a source number and its priority. It also holds the processor's current priority and a request priority for an inter-processor interrupt (IPI). It drives a single interrupt line to the processor. Sources offer delivery requests, each a source number and an 8-bit priority. Every request gets an accept or a refusal in the same cycle. A request that is more favoured than the stored one preempts the single pending slot. Any source interrupt that is displaced, or that is cleared when the processor raises its priority, is handed back on a reject channel.

The processor drives the unit through five register-style operations: acknowledge, poll, set current priority, set IPI priority and end-of-interrupt. The state read back is a 32-bit acknowledge word. The current processor priority is in bits 31:24 and the pending source number is in bits 23:0. Operations that find nothing pending ask the sources to offer their interrupts again, through a resend pulse. An end-of-interrupt is passed on to the sources.

Top module: `intr_present_unit`

## Requirements
- R1: After reset the acknowledge word is 0, the IPI priority reads 0xFF, the pending priority is 0xFF and `irq_o` is low.
- R2: `op_rdata` always shows {current priority, pending source number}. `irq_o` is high exactly when the source field is non-zero (zero means nothing pending). `op_ipi_prio` shows the IPI priority. A poll (op code 1) changes no state.
- R3: Each cycle with `req_valid` high produces exactly one of `req_ack` or `req_nak`. The request is refused when an operation is presented in the same cycle. It is also refused when its priority is not numerically lower than the current priority, or when a pending interrupt has a priority equal to or lower than it.
- R4: An accepted request stores its number and priority and raises `irq_o` on the next cycle. In the same cycle, if the displaced pending number belonged to a source, that number is given on `rej_valid`/`rej_src`.
- R5: Acknowledge (op code 0) returns the old word in that cycle. It then loads the pending priority into the current priority, clears the source field, sets the pending priority to 0xFF and lowers `irq_o`.
- R6: Set current priority (op code 2, value in `op_wdata[7:0]`) takes the new value. If that value is lower than the old one, something is pending and the value is less than or equal to the pending priority, the pending slot is cleared: the pending priority becomes 0xFF and `irq_o` goes low. A source-owned number cleared this way is rejected.
- R7: Set current priority with a value equal to or higher than the old one, while nothing is pending, pulses `resend_req`. If the IPI priority is then lower than the new current priority, the IPI is presented.
- R8: Set IPI priority (op code 3, value in `op_wdata[7:0]`) stores the value. If it is lower than the current priority and no pending interrupt has a priority less than or equal to it, the IPI is presented. Presenting the IPI loads source number 2 with the IPI priority, raises `irq_o` and rejects a displaced source-owned number.
- R9: End-of-interrupt (op code 4) copies `op_wdata[31:24]` into the current priority and pulses `eoi_valid` with `eoi_src = op_wdata[23:0]`. If nothing is pending, it also pulses `resend_req` and presents the IPI under the rule of R7.
- R10: Source number 2 (the IPI) never appears on the reject channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Delivery request from a source |
| req_src | input | 24 | Source number of the request |
| req_prio | input | 8 | Priority of the request |
| req_ack | output | 1 | Request taken into the pending slot |
| req_nak | output | 1 | Request refused; the source keeps it |
| op_valid | input | 1 | Processor operation strobe |
| op_code | input | 3 | 0 acknowledge, 1 poll, 2 set priority, 3 set IPI priority, 4 end-of-interrupt |
| op_wdata | input | 32 | Operation write value |
| op_rdata | output | 32 | Acknowledge word {current priority, pending number} |
| op_ipi_prio | output | 8 | IPI priority |
| rej_valid | output | 1 | A pending source number is handed back |
| rej_src | output | 24 | Number handed back |
| eoi_valid | output | 1 | End-of-interrupt forwarded to the sources |
| eoi_src | output | 24 | Number that ended |
| resend_req | output | 1 | Sources are asked to offer interrupts again |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
The hardest case to reach is an IPI displacing a source-owned pending interrupt. The stored request must sit at a priority worse than a newly written IPI priority, yet better than the current priority. Another hard case is an end-of-interrupt with an empty slot that must bring an earlier IPI request back. Random stimulus draws priorities from a narrow range, so equal and adjacent priorities come up often. A directed opening sequence walks through displacement, an IPI taking the slot, acknowledge, and an EOI that brings the IPI back.

// File: rtl/ipu_pkg.sv
package ipu_pkg;
    typedef enum logic [2:0] {
        OP_ACCEPT   = 3'd0,
        OP_POLL     = 3'd1,
        OP_SET_CPPR = 3'd2,
        OP_SET_IPI  = 3'd3,
        OP_EOI      = 3'd4
    } ipu_op_e;
endpackage

// File: rtl/ipu_ipi_eval.sv
// Decides whether an IPI at a given priority takes the pending slot.
module ipu_ipi_eval #(
    parameter int PRIO_W = 8,
    parameter int SRC_W  = 24
) (
    input  logic [PRIO_W-1:0] ipi_prio,
    input  logic [PRIO_W-1:0] thresh,
    input  logic [SRC_W-1:0]  cur_src,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic              cur_owned,
    output logic              present,
    output logic              displace
);
    logic busy_better;
    always_comb begin
        busy_better = (cur_src != '0) && (cur_prio <= ipi_prio);
        present     = (ipi_prio < thresh) && !busy_better;
        displace    = present && (cur_src != '0) && cur_owned;
    end
endmodule

// File: rtl/ipu_req_judge.sv
// Accept/refuse decision for an incoming source request.
module ipu_req_judge #(
    parameter int PRIO_W = 8,
    parameter int SRC_W  = 24
) (
    input  logic              req_valid,
    input  logic              op_busy,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic [PRIO_W-1:0] cur_cppr,
    input  logic [SRC_W-1:0]  cur_src,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic              cur_owned,
    output logic              take,
    output logic              refuse,
    output logic              displace
);
    logic blocked;
    always_comb begin
        blocked  = op_busy || (req_prio >= cur_cppr)
                   || ((cur_src != '0) && (cur_prio <= req_prio));
        take     = req_valid && !blocked;
        refuse   = req_valid && blocked;
        displace = take && (cur_src != '0) && cur_owned;
    end
endmodule

// File: rtl/intr_present_unit.sv
module intr_present_unit
    import ipu_pkg::*;
#(
    parameter int PRIO_W  = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [SRC_W-1:0]        req_src,
    input  logic [PRIO_W-1:0]       req_prio,
    output logic                    req_ack,
    output logic                    req_nak,
    input  logic                    op_valid,
    input  logic [2:0]              op_code,
    input  logic [PRIO_W+SRC_W-1:0] op_wdata,
    output logic [PRIO_W+SRC_W-1:0] op_rdata,
    output logic [PRIO_W-1:0]       op_ipi_prio,
    output logic                    rej_valid,
    output logic [SRC_W-1:0]        rej_src,
    output logic                    eoi_valid,
    output logic [SRC_W-1:0]        eoi_src,
    output logic                    resend_req,
    output logic                    irq_o
);
    localparam int WORD_W = PRIO_W + SRC_W;
    localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);
    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

    typedef struct packed {
        logic [PRIO_W-1:0] cppr;
        logic [SRC_W-1:0]  src;
        logic [PRIO_W-1:0] pprio;
        logic [PRIO_W-1:0] ipi;
        logic              owned;
        logic              irq;
    } ipu_state_t;

    ipu_state_t st_d, st_q;

    logic [PRIO_W-1:0] wr_low_d, wr_top_d, new_cppr_d;
    logic              set_present, set_displace;
    logic              rs_present, rs_displace;
    logic              rq_take, rq_refuse, rq_displace;

    assign wr_low_d   = op_wdata[PRIO_W-1:0];
    assign wr_top_d   = op_wdata[WORD_W-1:SRC_W];
    assign new_cppr_d = (op_code == OP_EOI) ? wr_top_d : wr_low_d;

    // IPI check for a write of the IPI priority
    ipu_ipi_eval #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_ipi_set (
        .ipi_prio (wr_low_d),
        .thresh   (st_q.cppr),
        .cur_src  (st_q.src),
        .cur_prio (st_q.pprio),
        .cur_owned(st_q.owned),
        .present  (set_present),
        .displace (set_displace)
    );

    // IPI check on the resend path, against the newly written priority
    ipu_ipi_eval #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_ipi_resend (
        .ipi_prio (st_q.ipi),
        .thresh   (new_cppr_d),
        .cur_src  (st_q.src),
        .cur_prio (st_q.pprio),
        .cur_owned(st_q.owned),
        .present  (rs_present),
        .displace (rs_displace)
    );

    ipu_req_judge #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_judge (
        .req_valid(req_valid),
        .op_busy  (op_valid),
        .req_prio (req_prio),
        .cur_cppr (st_q.cppr),
        .cur_src  (st_q.src),
        .cur_prio (st_q.pprio),
        .cur_owned(st_q.owned),
        .take     (rq_take),
        .refuse   (rq_refuse),
        .displace (rq_displace)
    );

    always_comb begin
        st_d       = st_q;
        rej_valid  = 1'b0;
        rej_src    = st_q.src;
        eoi_valid  = 1'b0;
        eoi_src    = op_wdata[SRC_W-1:0];
        resend_req = 1'b0;
        if (op_valid) begin
            case (op_code)
                OP_ACCEPT: begin
                    st_d.cppr  = st_q.pprio;
                    st_d.src   = '0;
                    st_d.pprio = PRIO_NONE;
                    st_d.owned = 1'b0;
                    st_d.irq   = 1'b0;
                end
                OP_SET_CPPR: begin
                    st_d.cppr = wr_low_d;
                    if (wr_low_d < st_q.cppr) begin
                        if ((st_q.src != '0) && (wr_low_d <= st_q.pprio)) begin
                            rej_valid  = st_q.owned;
                            st_d.src   = '0;
                            st_d.pprio = PRIO_NONE;
                            st_d.owned = 1'b0;
                            st_d.irq   = 1'b0;
                        end
                    end else if (st_q.src == '0) begin
                        resend_req = 1'b1;
                        if (rs_present) begin
                            rej_valid  = rs_displace;
                            st_d.src   = IPI_NUM;
                            st_d.pprio = st_q.ipi;
                            st_d.owned = 1'b0;
                            st_d.irq   = 1'b1;
                        end
                    end
                end
                OP_SET_IPI: begin
                    st_d.ipi = wr_low_d;
                    if (set_present) begin
                        rej_valid  = set_displace;
                        st_d.src   = IPI_NUM;
                        st_d.pprio = wr_low_d;
                        st_d.owned = 1'b0;
                        st_d.irq   = 1'b1;
                    end
                end
                OP_EOI: begin
                    st_d.cppr = wr_top_d;
                    eoi_valid = 1'b1;
                    if (st_q.src == '0) begin
                        resend_req = 1'b1;
                        if (rs_present) begin
                            rej_valid  = rs_displace;
                            st_d.src   = IPI_NUM;
                            st_d.pprio = st_q.ipi;
                            st_d.owned = 1'b0;
                            st_d.irq   = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end else if (rq_take) begin
            rej_valid  = rq_displace;
            st_d.src   = req_src;
            st_d.pprio = req_prio;
            st_d.owned = 1'b1;
            st_d.irq   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cppr: '0, src: '0, pprio: PRIO_NONE, ipi: PRIO_NONE,
                      owned: 1'b0, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ack     = rq_take;
    assign req_nak     = rq_refuse;
    assign op_rdata    = {st_q.cppr, st_q.src};
    assign op_ipi_prio = st_q.ipi;
    assign irq_o       = st_q.irq;

    // R2: line and pending field agree
    a_r2_line_matches_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (op_rdata[SRC_W-1:0] != '0));
    // R2: poll leaves the readable state alone
    a_r2_poll_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_POLL) |=> ($stable(op_rdata) && $stable(op_ipi_prio)));
    // R3: exactly one answer per request
    a_r3_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_ack != req_nak));
    // R3: no answer without a request
    a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!req_ack && !req_nak));
    // R3: an operation in the same cycle refuses the request
    a_r3_op_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && req_valid) |-> req_nak);
    // R4: a taken request shows up next cycle
    a_r4_ack_presents: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> (irq_o && op_rdata[SRC_W-1:0] == $past(req_src)));
    // R5: acknowledge empties the slot
    a_r5_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ACCEPT) |=> (!irq_o && op_rdata[SRC_W-1:0] == '0));
    // R10: the IPI number is never handed back
    a_r10_ipi_not_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> (rej_src != IPI_NUM));
endmodule

// File: tb/intr_present_unit_tb_top.sv
module intr_present_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_src = '0;
    logic [7:0]  req_prio = '0;
    logic        req_ack, req_nak;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] op_wdata = '0;
    logic [31:0] op_rdata;
    logic [7:0]  op_ipi_prio;
    logic        rej_valid, eoi_valid, resend_req, irq_o;
    logic [23:0] rej_src, eoi_src;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference state
    logic [7:0]  m_cppr, m_pprio, m_ipi;
    logic [23:0] m_src;
    logic        m_owned, m_irq;
    // expected outputs of the current cycle
    logic        e_ack, e_nak, e_rej, e_eoi, e_resend;
    logic [23:0] e_rej_src, e_eoi_src;

    always #2 clk = ~clk;

    intr_present_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
        .req_ack(req_ack), .req_nak(req_nak),
        .op_valid(op_valid), .op_code(op_code), .op_wdata(op_wdata),
        .op_rdata(op_rdata), .op_ipi_prio(op_ipi_prio),
        .rej_valid(rej_valid), .rej_src(rej_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .resend_req(resend_req), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit ipi_wins(input logic [7:0] p, input logic [7:0] thr);
        return (p < thr) && !((m_src != 0) && (m_pprio <= p));
    endfunction

    task automatic put_ipi(input logic [7:0] p);
        if (m_src != 0 && m_owned) begin
            e_rej = 1'b1; e_rej_src = m_src;
        end
        m_src = 24'd2; m_pprio = p; m_owned = 1'b0; m_irq = 1'b1;
    endtask

    task automatic model_reset();
        m_cppr = 0; m_src = 0; m_pprio = 8'hFF; m_ipi = 8'hFF;
        m_owned = 0; m_irq = 0;
    endtask

    // compute expected outputs from the pre-state, then advance the model
    task automatic model_step(input bit ov, input logic [2:0] oc, input logic [31:0] wd,
                              input bit rv, input logic [23:0] rs, input logic [7:0] rp);
        logic [7:0] lo, hi;
        lo = wd[7:0]; hi = wd[31:24];
        e_ack = 0; e_nak = 0; e_rej = 0; e_rej_src = 0; e_eoi = 0;
        e_eoi_src = 0; e_resend = 0;
        if (rv) begin
            if (ov || rp >= m_cppr || (m_src != 0 && m_pprio <= rp)) e_nak = 1;
            else e_ack = 1;
        end
        if (ov) begin
            case (oc)
                3'd0: begin
                    m_cppr = m_pprio; m_src = 0; m_pprio = 8'hFF;
                    m_owned = 0; m_irq = 0;
                end
                3'd2: begin
                    if (lo < m_cppr) begin
                        m_cppr = lo;
                        if (m_src != 0 && lo <= m_pprio) begin
                            if (m_owned) begin e_rej = 1; e_rej_src = m_src; end
                            m_src = 0; m_pprio = 8'hFF; m_owned = 0; m_irq = 0;
                        end
                    end else begin
                        m_cppr = lo;
                        if (m_src == 0) begin
                            e_resend = 1;
                            if (ipi_wins(m_ipi, lo)) put_ipi(m_ipi);
                        end
                    end
                end
                3'd3: begin
                    m_ipi = lo;
                    if (ipi_wins(lo, m_cppr)) put_ipi(lo);
                end
                3'd4: begin
                    m_cppr = hi; e_eoi = 1; e_eoi_src = wd[23:0];
                    if (m_src == 0) begin
                        e_resend = 1;
                        if (ipi_wins(m_ipi, hi)) put_ipi(m_ipi);
                    end
                end
                default: ;
            endcase
        end else if (e_ack) begin
            if (m_src != 0 && m_owned) begin e_rej = 1; e_rej_src = m_src; end
            m_src = rs; m_pprio = rp; m_owned = 1; m_irq = 1;
        end
    endtask

    task automatic cyc(input bit ov, input logic [2:0] oc, input logic [31:0] wd,
                       input bit rv, input logic [23:0] rs, input logic [7:0] rp);
        string t;
        @(negedge clk);
        op_valid = ov; op_code = oc; op_wdata = wd;
        req_valid = rv; req_src = rs; req_prio = rp;
        #1;
        chk("R2", "op_rdata", op_rdata, {m_cppr, m_src});
        chk("R2", "irq_o", {31'd0, irq_o}, {31'd0, m_irq});
        chk("R2", "op_ipi_prio", {24'd0, op_ipi_prio}, {24'd0, m_ipi});
        if (!ov) t = "R4";
        else case (oc)
            3'd0: t = "R5";
            3'd1: t = "R2";
            3'd2: t = (wd[7:0] < m_cppr) ? "R6" : "R7";
            3'd3: t = "R8";
            default: t = "R9";
        endcase
        model_step(ov, oc, wd, rv, rs, rp);
        chk("R3", "req_ack", {31'd0, req_ack}, {31'd0, e_ack});
        chk("R3", "req_nak", {31'd0, req_nak}, {31'd0, e_nak});
        chk(t, "rej_valid", {31'd0, rej_valid}, {31'd0, e_rej});
        if (e_rej) chk(t, "rej_src", {8'd0, rej_src}, {8'd0, e_rej_src});
        if (rej_valid) chk("R10", "rej_src not IPI", {31'd0, rej_src == 24'd2}, 32'd0);
        chk(t, "eoi_valid", {31'd0, eoi_valid}, {31'd0, e_eoi});
        if (e_eoi) chk("R9", "eoi_src", {8'd0, eoi_src}, {8'd0, e_eoi_src});
        chk(t, "resend_req", {31'd0, resend_req}, {31'd0, e_resend});
    endtask

    function automatic logic [7:0] rnd_prio();
        return ($urandom_range(0, 9) == 0) ? 8'hFF : 8'($urandom_range(0, 15));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "word", op_rdata, 32'd0);
        chk("R1", "ipi prio", {24'd0, op_ipi_prio}, 32'hFF);
        chk("R1", "irq", {31'd0, irq_o}, 32'd0);
        // R3: priority 5 not below current priority 0
        cyc(0, 0, 0, 1, 24'h10, 8'd5);
        // R7: raise current priority to 0xFF with nothing pending
        cyc(1, 3'd2, 32'hFF, 0, 0, 0);
        cyc(0, 0, 0, 1, 24'h10, 8'd5);          // R4: taken
        cyc(0, 0, 0, 1, 24'h20, 8'd5);          // R3: equal priority refused
        cyc(0, 0, 0, 1, 24'h30, 8'd3);          // R4: displaces 0x10
        cyc(1, 3'd1, 0, 1, 24'h31, 8'd0);       // R2/R3: poll, collision refuses
        cyc(1, 3'd3, 32'h4, 0, 0, 0);           // R8: pending 3 <= 4, no IPI
        cyc(1, 3'd3, 32'h2, 0, 0, 0);           // R8: IPI displaces 0x30
        cyc(0, 0, 0, 1, 24'h40, 8'd1);          // R10: IPI displaced without reject
        cyc(1, 3'd0, 0, 0, 0, 0);               // R5: acknowledge 0x40
        cyc(1, 3'd2, 32'h1, 0, 0, 0);           // R7: equal priority, resend
        cyc(1, 3'd4, 32'hFF000040, 0, 0, 0);    // R9: EOI brings IPI back
        cyc(1, 3'd2, 32'h1, 0, 0, 0);           // R6: clears IPI, no reject
        cyc(0, 0, 0, 0, 0, 0);
        chk("R6", "cleared slot", {31'd0, irq_o}, 32'd0);
        cyc(1, 3'd2, 32'h8, 0, 0, 0);           // R7
        for (int i = 0; i < 4000; i++) begin
            bit ov, rv;
            logic [2:0] oc;
            logic [31:0] wd;
            ov = ($urandom_range(0, 9) < 3);
            rv = ($urandom_range(0, 9) < 6);
            oc = 3'($urandom_range(0, 4));
            wd = {rnd_prio(), 24'($urandom_range(3, 300))};
            if (oc != 3'd4) wd = {24'd0, rnd_prio()};
            cyc(ov, oc, wd, rv, 24'($urandom_range(3, 300)), rnd_prio());
        end
        cyc(0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule